// File: doc/BRIEF.md
# Panel Register Initialization Sequencer

This block programs the configuration registers of an 800x480 LCD panel controller over its serial control port. A one-cycle start request makes it walk a fixed, built-in list of register writes from the first entry to the last. Each write goes out as a single 32-bit SPI frame, most significant bit first, in SPI mode 0. All writes except the final one are sent back to back. A timed pause comes before the final write, because that write releases the controller from standby and the controller needs the earlier settings to settle first.

Two more requests manage standby. A sleep request writes the standby register to 1 and then keeps the block busy for a settle window. A wake request writes the standby register to 0 and then replays the whole initialization list, including the pause before the last write. The block raises a busy flag for the length of an operation. It pulses done for one cycle when the operation ends. The SCLK half period, the gap between frames, the pause and the sleep settle time are all parameters counted in system clock cycles. At 125 MHz the default values give a 20 us pause and a 40 ms settle time.

Top module: `panel_init_seq`

## Requirements
- R1: Every register write is one 32-bit frame laid out as {8'h00, address[7:0], 8'h01, data[7:0]}, shifted out most significant bit first.
- R2: SPI mode 0 applies. SCLK is low whenever chip select is high. MOSI changes only while SCLK is low, so it is stable across every rising SCLK edge.
- R3: Chip select stays low for exactly 32 rising SCLK edges per frame. Between two ordinary frames it stays high for at least one SCLK period (2*HALF_DIV clock cycles) and for less than PAUSE_CYC cycles.
- R4: The list has ROM_DEPTH entries (default 81), sent in index order. Entry 0 writes address 3 with 8'h01. The last entry writes address 2 with 8'h00. Each entry i in between writes address i+3 with data (i*37+5) mod 256.
- R5: Between the end of frame ROM_DEPTH-2 (chip select rising) and the start of the final frame (chip select falling), at least PAUSE_CYC clock cycles pass.
- R6: A sleep request sends exactly one frame, which writes address 2 with 8'h01 (word 32'h00020101). Busy then stays high for at least HOLD_CYC cycles after chip select rises at the end of that frame.
- R7: A wake request sends the word 32'h00020100 first. It then sends the full list of R4, with the pause of R5, for ROM_DEPTH+1 frames in total.
- R8: While busy is high, start, sleep and wake requests have no effect. No frame comes from them, either during the operation or after it.
- R9: If several requests arrive together while idle, start wins over wake, and wake wins over sleep.
- R10: An accepted request raises busy in the next cycle. When an operation completes, done is high for exactly one cycle, and that cycle is the first cycle in which busy is low again.
- R11: A synchronous active-high reset aborts any operation. From the next cycle, chip select is high, SCLK is low, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request: send the full initialization list |
| sleep_req | input | 1 | Request: put the panel in standby |
| wake_req | input | 1 | Request: leave standby and reinitialize |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The bound checker enforces the serial protocol on every cycle. It checks that SCLK stays quiet while chip select is high, that MOSI holds steady across SCLK-high phases, and that each frame carries exactly 32 rising edges. It also checks that busy rises after an accepted request, that done coincides with busy falling, and that the outputs are idle after reset. Only the bench scenarios can show the things that depend on the whole list or on wall time: the frame contents and their order, the length of the pause before the final write, the sleep settle window, the replay after wake, the priority among simultaneous requests, and the fact that requests made while busy leave no trace.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

   localparam int unsigned FRAME_BITS = 32;
   localparam logic [7:0]  STBY_ADDR  = 8'd2;

   typedef struct packed {
      logic [7:0] addr;
      logic [7:0] data;
   } reg_wr_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_STBY,
      SQ_LIST,
      SQ_PAUSE,
      SQ_HOLD
   } seq_state_e;

   // Content of list entry idx for a list of depth entries.
   function automatic reg_wr_t list_entry(input int unsigned idx, input int unsigned depth);
      reg_wr_t e;
      if (idx == 0) begin
         e.addr = 8'd3;
         e.data = 8'h01;
      end else if (idx == depth - 1) begin
         e.addr = STBY_ADDR;
         e.data = 8'h00;
      end else begin
         e.addr = 8'(idx + 3);
         e.data = 8'((idx * 37 + 5) % 256);
      end
      return e;
   endfunction

   // Command half carries the address, data half carries the value.
   function automatic logic [FRAME_BITS-1:0] pack_frame(input reg_wr_t e);
      return {8'h00, e.addr, 8'h01, e.data};
   endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
   import panel_seq_pkg::*;
#(
   parameter int unsigned DEPTH = 81,
   parameter int unsigned IDXW  = $clog2(DEPTH)
) (
   input  logic [IDXW-1:0] idx,
   output reg_wr_t         entry
);

   localparam int unsigned TBL_SIZE = 2 ** IDXW;

   reg_wr_t tbl [TBL_SIZE];

   for (genvar g = 0; g < TBL_SIZE; g++) begin : g_tbl
      if (g < DEPTH) begin : g_used
         assign tbl[g] = list_entry(g, DEPTH);
      end else begin : g_pad
         assign tbl[g] = '0;
      end
   end

   assign entry = tbl[idx];

endmodule

// File: rtl/panel_spi_shifter.sv
module panel_spi_shifter
   import panel_seq_pkg::*;
#(
   parameter int unsigned HALF_DIV = 3,
   parameter int unsigned GAP_CYC  = 8,
   parameter int unsigned NBITS    = FRAME_BITS
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [NBITS-1:0] word,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n,
   output logic             frame_done
);

   localparam int unsigned DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int unsigned GAPW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam int unsigned BITW = $clog2(NBITS);
   localparam logic [DIVW-1:0] DIV_LAST = DIVW'(HALF_DIV - 1);
   localparam logic [GAPW-1:0] GAP_LAST = GAPW'(GAP_CYC - 1);
   localparam logic [BITW-1:0] BIT_LAST = BITW'(NBITS - 1);

   typedef enum logic [1:0] {TX_IDLE, TX_SHIFT, TX_GAP} tx_state_e;

   tx_state_e        st;
   logic [NBITS-1:0] shreg;
   logic [DIVW-1:0]  divcnt;
   logic [BITW-1:0]  bitcnt;
   logic [GAPW-1:0]  gapcnt;

   always_ff @(posedge clk) begin
      frame_done <= 1'b0;
      if (rst) begin
         st     <= TX_IDLE;
         cs_n   <= 1'b1;
         sclk   <= 1'b0;
         shreg  <= '0;
         divcnt <= '0;
         bitcnt <= '0;
         gapcnt <= '0;
      end else begin
         case (st)
            TX_IDLE: begin
               if (start) begin
                  shreg  <= word;
                  cs_n   <= 1'b0;
                  divcnt <= '0;
                  bitcnt <= '0;
                  st     <= TX_SHIFT;
               end
            end
            TX_SHIFT: begin
               if (divcnt == DIV_LAST) begin
                  divcnt <= '0;
                  if (!sclk) begin
                     sclk <= 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (bitcnt == BIT_LAST) begin
                        cs_n   <= 1'b1;
                        gapcnt <= '0;
                        st     <= TX_GAP;
                     end else begin
                        shreg  <= {shreg[NBITS-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end else begin
                  divcnt <= divcnt + 1'b1;
               end
            end
            TX_GAP: begin
               if (gapcnt == GAP_LAST) begin
                  frame_done <= 1'b1;
                  st         <= TX_IDLE;
               end else begin
                  gapcnt <= gapcnt + 1'b1;
               end
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   assign mosi = cs_n ? 1'b0 : shreg[NBITS-1];

endmodule

// File: rtl/panel_wait_timer.sv
module panel_wait_timer #(
   parameter int unsigned TW = 23
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt;
   logic          running;

   always_ff @(posedge clk) begin
      expired <= 1'b0;
      if (rst) begin
         cnt     <= '0;
         running <= 1'b0;
      end else if (load) begin
         cnt     <= load_val;
         running <= 1'b1;
      end else if (running) begin
         if (cnt <= TW'(1)) begin
            expired <= 1'b1;
            running <= 1'b0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
   import panel_seq_pkg::*;
#(
   parameter int unsigned ROM_DEPTH = 81,
   parameter int unsigned IDXW      = $clog2(ROM_DEPTH),
   parameter int unsigned PAUSE_CYC = 2500,
   parameter int unsigned HOLD_CYC  = 5000000,
   parameter int unsigned TW        = 23
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start_req,
   input  logic                  sleep_req,
   input  logic                  wake_req,
   input  logic                  frame_done,
   input  logic                  tmr_expired,
   input  reg_wr_t               list_wr,
   output logic [IDXW-1:0]       list_idx,
   output logic                  tx_start,
   output logic [FRAME_BITS-1:0] tx_word,
   output logic                  tmr_load,
   output logic [TW-1:0]         tmr_val,
   output logic                  busy,
   output logic                  done
);

   localparam logic [IDXW-1:0] IDX_LAST = IDXW'(ROM_DEPTH - 1);
   localparam logic [IDXW-1:0] IDX_PRE  = IDXW'(ROM_DEPTH - 2);

   seq_state_e st;
   logic       stby_wake;
   logic       inflight;
   reg_wr_t    stby_wr;

   always_comb begin
      stby_wr.addr = STBY_ADDR;
      stby_wr.data = {7'd0, ~stby_wake};
   end

   assign tx_word  = (st == SQ_STBY) ? pack_frame(stby_wr) : pack_frame(list_wr);
   assign tx_start = ((st == SQ_STBY) || (st == SQ_LIST)) && !inflight;
   assign tmr_load = frame_done &&
                     (((st == SQ_STBY) && !stby_wake) ||
                      ((st == SQ_LIST) && (list_idx == IDX_PRE)));
   assign tmr_val  = (st == SQ_STBY) ? TW'(HOLD_CYC) : TW'(PAUSE_CYC);
   assign busy     = (st != SQ_IDLE);

   always_ff @(posedge clk) begin
      done <= 1'b0;
      if (rst) begin
         st        <= SQ_IDLE;
         list_idx  <= '0;
         stby_wake <= 1'b0;
         inflight  <= 1'b0;
      end else begin
         if (tx_start) begin
            inflight <= 1'b1;
         end else if (frame_done) begin
            inflight <= 1'b0;
         end
         case (st)
            SQ_IDLE: begin
               if (start_req) begin
                  list_idx <= '0;
                  st       <= SQ_LIST;
               end else if (wake_req) begin
                  stby_wake <= 1'b1;
                  st        <= SQ_STBY;
               end else if (sleep_req) begin
                  stby_wake <= 1'b0;
                  st        <= SQ_STBY;
               end
            end
            SQ_STBY: begin
               if (frame_done) begin
                  if (stby_wake) begin
                     list_idx <= '0;
                     st       <= SQ_LIST;
                  end else begin
                     st <= SQ_HOLD;
                  end
               end
            end
            SQ_LIST: begin
               if (frame_done) begin
                  if (list_idx == IDX_LAST) begin
                     st   <= SQ_IDLE;
                     done <= 1'b1;
                  end else begin
                     list_idx <= list_idx + 1'b1;
                     if (list_idx == IDX_PRE) begin
                        st <= SQ_PAUSE;
                     end
                  end
               end
            end
            SQ_PAUSE: begin
               if (tmr_expired) begin
                  st <= SQ_LIST;
               end
            end
            SQ_HOLD: begin
               if (tmr_expired) begin
                  st   <= SQ_IDLE;
                  done <= 1'b1;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/panel_init_seq.sv
module panel_init_seq
   import panel_seq_pkg::*;
#(
   parameter int unsigned ROM_DEPTH = 81,
   parameter int unsigned HALF_DIV  = 3,
   parameter int unsigned GAP_CYC   = 8,
   parameter int unsigned PAUSE_CYC = 2500,
   parameter int unsigned HOLD_CYC  = 5000000
) (
   input  logic clk,
   input  logic rst,
   input  logic start_req,
   input  logic sleep_req,
   input  logic wake_req,
   output logic spi_sclk,
   output logic spi_mosi,
   output logic spi_cs_n,
   output logic busy,
   output logic done
);

   localparam int unsigned IDXW = $clog2(ROM_DEPTH);
   localparam int unsigned TMAX = (HOLD_CYC > PAUSE_CYC) ? HOLD_CYC : PAUSE_CYC;
   localparam int unsigned TW   = $clog2(TMAX + 1);

   if (ROM_DEPTH < 2 || ROM_DEPTH > 253) begin : g_bad_depth
      $error("ROM_DEPTH must lie in 2..253");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (GAP_CYC < 2 * HALF_DIV) begin : g_bad_gap
      $error("GAP_CYC must cover one SCLK period");
   end
   if (PAUSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_wait
      $error("PAUSE_CYC and HOLD_CYC must be nonzero");
   end

   logic [IDXW-1:0]       list_idx;
   reg_wr_t               list_wr;
   logic                  tx_start;
   logic [FRAME_BITS-1:0] tx_word;
   logic                  frame_done;
   logic                  tmr_load;
   logic [TW-1:0]         tmr_val;
   logic                  tmr_expired;

   panel_seq_rom #(
      .DEPTH (ROM_DEPTH),
      .IDXW  (IDXW)
   ) rom_i (
      .idx   (list_idx),
      .entry (list_wr)
   );

   panel_seq_ctrl #(
      .ROM_DEPTH (ROM_DEPTH),
      .IDXW      (IDXW),
      .PAUSE_CYC (PAUSE_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .TW        (TW)
   ) ctrl_i (
      .clk         (clk),
      .rst         (rst),
      .start_req   (start_req),
      .sleep_req   (sleep_req),
      .wake_req    (wake_req),
      .frame_done  (frame_done),
      .tmr_expired (tmr_expired),
      .list_wr     (list_wr),
      .list_idx    (list_idx),
      .tx_start    (tx_start),
      .tx_word     (tx_word),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .busy        (busy),
      .done        (done)
   );

   panel_spi_shifter #(
      .HALF_DIV (HALF_DIV),
      .GAP_CYC  (GAP_CYC),
      .NBITS    (FRAME_BITS)
   ) tx_i (
      .clk        (clk),
      .rst        (rst),
      .start      (tx_start),
      .word       (tx_word),
      .sclk       (spi_sclk),
      .mosi       (spi_mosi),
      .cs_n       (spi_cs_n),
      .frame_done (frame_done)
   );

   panel_wait_timer #(
      .TW (TW)
   ) tmr_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

endmodule

// File: rtl/panel_init_seq_chk.sv
module panel_init_seq_chk (
   input logic clk,
   input logic rst,
   input logic start_req,
   input logic sleep_req,
   input logic wake_req,
   input logic spi_sclk,
   input logic spi_mosi,
   input logic spi_cs_n,
   input logic busy,
   input logic done
);

   logic       sclk_q;
   logic [5:0] rise_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q   <= 1'b0;
         rise_cnt <= '0;
      end else begin
         sclk_q <= spi_sclk;
         if (spi_cs_n) begin
            rise_cnt <= '0;
         end else if (spi_sclk && !sclk_q) begin
            rise_cnt <= rise_cnt + 1'b1;
         end
      end
   end

   // R2
   cs_idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
      spi_cs_n |-> !spi_sclk);

   // R2
   mosi_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

   // R3
   frame_edges_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(spi_cs_n) && !$past(rst)) |-> (rise_cnt == 6'd32));

   // R10
   busy_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && (start_req || wake_req || sleep_req)) |=> busy);

   // R10
   done_at_busy_end_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy)));

   // R11
   reset_idle_chk: assert property (@(posedge clk)
      $past(rst) |-> (spi_cs_n && !spi_sclk && !busy && !done));

endmodule

bind panel_init_seq panel_init_seq_chk chk_i (
   .clk       (clk),
   .rst       (rst),
   .start_req (start_req),
   .sleep_req (sleep_req),
   .wake_req  (wake_req),
   .spi_sclk  (spi_sclk),
   .spi_mosi  (spi_mosi),
   .spi_cs_n  (spi_cs_n),
   .busy      (busy),
   .done      (done)
);

// File: tb/panel_init_seq_tb_top.sv
module panel_init_seq_tb_top;

   localparam int HALF  = 2;
   localparam int GAP   = 4;
   localparam int PAUSE = 200;
   localparam int HOLD  = 300;
   localparam int DEPTH = 81;
   localparam int WDOG  = 190000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_req = 1'b0;
   logic sleep_req = 1'b0;
   logic wake_req = 1'b0;
   logic sclk, mosi, csn, busy, done;

   always #4 clk = ~clk;

   panel_init_seq #(
      .ROM_DEPTH (DEPTH),
      .HALF_DIV  (HALF),
      .GAP_CYC   (GAP),
      .PAUSE_CYC (PAUSE),
      .HOLD_CYC  (HOLD)
   ) dut_i (
      .clk       (clk),
      .rst       (rst),
      .start_req (start_req),
      .sleep_req (sleep_req),
      .wake_req  (wake_req),
      .spi_sclk  (sclk),
      .spi_mosi  (mosi),
      .spi_cs_n  (csn),
      .busy      (busy),
      .done      (done)
   );

   int checks = 0;
   int errors = 0;

   // passive monitor of the serial port
   int          cyc = 0;
   logic [31:0] sh = '0;
   int          bits = 0;
   int          nfr = 0;
   logic [31:0] fr_word [512];
   int          fr_bits [512];
   int          fr_rise [512];
   int          fr_fall [512];
   int          busy_fall = 0;
   int          done_cnt = 0;
   int          done_long = 0;
   int          mode_err = 0;
   logic        p_sclk = 1'b0, p_csn = 1'b1, p_busy = 1'b0, p_done = 1'b0, p_mosi = 1'b0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      p_sclk <= sclk; p_csn <= csn; p_busy <= busy; p_done <= done; p_mosi <= mosi;
      if (!rst) begin
         if (!csn && sclk && !p_sclk) begin
            sh   <= {sh[30:0], mosi};
            bits <= bits + 1;
         end
         if (csn && !p_csn) begin
            fr_word[nfr] <= sh;
            fr_bits[nfr] <= bits;
            fr_rise[nfr] <= cyc;
            nfr <= nfr + 1;
         end
         if (!csn && p_csn) begin
            fr_fall[nfr] <= cyc;
            bits <= 0;
         end
         if (!busy && p_busy) busy_fall <= cyc;
         if (done) done_cnt <= done_cnt + 1;
         if (done && p_done) done_long <= done_long + 1;
         if ((csn && sclk) || (sclk && p_sclk && mosi != p_mosi)) mode_err <= mode_err + 1;
      end
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
   end

   function automatic logic [31:0] exp_word(input int i);
      logic [7:0] a, d;
      if (i == 0) begin
         a = 8'd3; d = 8'h01;
      end else if (i == DEPTH - 1) begin
         a = 8'd2; d = 8'h00;
      end else begin
         a = 8'(i + 3); d = 8'((i * 37 + 5) % 256);
      end
      return {8'h00, a, 8'h01, d};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic pulse(input bit s, input bit sl, input bit w);
      start_req = s; sleep_req = sl; wake_req = w;
      @(negedge clk);
      start_req = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
   endtask

   task automatic wait_done(input int d0, input int maxc);
      int n = 0;
      while (done_cnt <= d0 && n < maxc) begin
         @(negedge clk);
         n++;
      end
      chk(done_cnt > d0, "R10", "operation completes", done_cnt, d0 + 1);
      repeat (4) @(negedge clk);
   endtask

   // list sent from frame index first
   task automatic check_list(input int first);
      for (int i = 0; i < DEPTH; i++) begin
         chk(fr_word[first + i] == exp_word(i), "R4", "list word", fr_word[first + i], exp_word(i));
         chk(fr_bits[first + i] == 32, "R3", "edges per frame", fr_bits[first + i], 32);
      end
      for (int i = 0; i < DEPTH - 1; i++) begin
         int gap;
         gap = fr_fall[first + i + 1] - fr_rise[first + i];
         if (i == DEPTH - 2)
            chk(gap >= PAUSE, "R5", "pause before final", gap, PAUSE);
         else
            chk(gap >= 2 * HALF && gap < PAUSE, "R3", "inter-frame gap", gap, 2 * HALF);
      end
   endtask

   initial begin
      int base, d0;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(csn === 1'b1, "R11", "cs after reset", csn, 1);
      chk(sclk === 1'b0, "R11", "sclk after reset", sclk, 0);
      chk(busy === 1'b0, "R11", "busy after reset", busy, 0);
      chk(done === 1'b0, "R11", "done after reset", done, 0);

      // plain start, with requests thrown in while busy
      base = nfr; d0 = done_cnt;
      pulse(1, 0, 0);
      chk(busy === 1'b1, "R10", "busy after start", busy, 1);
      repeat (1000) @(negedge clk);
      pulse(1, 1, 1);
      wait_done(d0, 30000);
      chk(nfr - base == DEPTH, "R4", "frame count", nfr - base, DEPTH);
      chk(fr_word[base] == 32'h00030101, "R1", "first frame layout", fr_word[base], 32'h00030101);
      check_list(base);
      chk(done_cnt == d0 + 1 && done_long == 0, "R10", "single done pulse", done_cnt - d0, 1);
      chk(busy === 1'b0, "R10", "idle after done", busy, 0);
      repeat (2000) @(negedge clk);
      chk(nfr - base == DEPTH, "R8", "no frames from busy requests", nfr - base, DEPTH);
      chk(busy === 1'b0, "R8", "no operation from busy requests", busy, 0);

      // sleep
      base = nfr; d0 = done_cnt;
      pulse(0, 1, 0);
      chk(busy === 1'b1, "R10", "busy after sleep", busy, 1);
      wait_done(d0, 5000);
      chk(nfr - base == 1, "R6", "sleep frame count", nfr - base, 1);
      chk(fr_word[base] == 32'h00020101, "R6", "sleep word", fr_word[base], 32'h00020101);
      chk(busy_fall - fr_rise[base] >= HOLD, "R6", "settle hold", busy_fall - fr_rise[base], HOLD);

      // wake
      base = nfr; d0 = done_cnt;
      pulse(0, 0, 1);
      wait_done(d0, 30000);
      chk(nfr - base == DEPTH + 1, "R7", "wake frame count", nfr - base, DEPTH + 1);
      chk(fr_word[base] == 32'h00020100, "R7", "wake word", fr_word[base], 32'h00020100);
      chk(fr_bits[base] == 32, "R3", "edges in wake frame", fr_bits[base], 32);
      check_list(base + 1);

      // priority: all three together
      base = nfr; d0 = done_cnt;
      pulse(1, 1, 1);
      wait_done(d0, 30000);
      chk(nfr - base == DEPTH, "R9", "start wins count", nfr - base, DEPTH);
      chk(fr_word[base] == exp_word(0), "R9", "start wins first word", fr_word[base], exp_word(0));

      // priority: wake over sleep
      base = nfr; d0 = done_cnt;
      pulse(0, 1, 1);
      wait_done(d0, 30000);
      chk(nfr - base == DEPTH + 1, "R9", "wake wins count", nfr - base, DEPTH + 1);
      chk(fr_word[base] == 32'h00020100, "R9", "wake wins first word", fr_word[base], 32'h00020100);

      // reset in the middle of an operation
      d0 = done_cnt;
      pulse(1, 0, 0);
      repeat (301) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(csn === 1'b1, "R11", "cs after abort", csn, 1);
      chk(sclk === 1'b0, "R11", "sclk after abort", sclk, 0);
      chk(busy === 1'b0, "R11", "busy after abort", busy, 0);
      repeat (500) @(negedge clk);
      chk(busy === 1'b0 && done_cnt == d0, "R11", "stays idle after abort", done_cnt, d0);

      chk(mode_err == 0, "R2", "mode 0 violations", mode_err, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule